// File: doc/BRIEF.md
# Word and Byte Program Sequencer with Conditional Erase

This block sits between the processor's store path and a non-volatile array that is organised in 32-bit words. It turns processor stores into erase and write cycles on that array. In single-byte mode, any accepted store starts a cycle at once. The containing word is fetched, the new byte is merged into it, and the full word is written back. In four-byte mode, the block collects four stores to consecutive offsets of one word, starting at the word's first byte. The cycle is launched when the fourth byte arrives.

Before the write phase, the sequencer runs an erase phase only if the fetched word is not blank. A blank word is all zeros. A fixed-duration control input forces the erase phase on every cycle, so every operation takes the same time. While a cycle runs, the block raises a stall output that holds off further processor accesses to the array. When the cycle ends, a completion flag is set, and it can raise an interrupt. A refused store sets a protection-violation flag. Both flags clear on a status read or when the next operation starts.

Top module: `flashwp_ctrl`

## Requirements
- R1: After reset, stall, done, wp_err and irq are 0, and every byte of the array reads 0x00.
- R2: With word_mode=0, an accepted store starts a cycle that writes the byte at its address. The other three bytes of the containing word keep their values. Address bits [1:0] select the byte, with byte k held in bits 8k+7:8k of the word.
- R3: An operation whose fetched word is all zeros, with fixed_time=0, holds stall high for exactly 1+PROG_CYC cycles. With defaults this is 5 cycles, and it starts on the cycle after the store is accepted.
- R4: An operation whose fetched word is nonzero holds stall high for exactly 1+ERASE_CYC+PROG_CYC cycles. With defaults this is 11 cycles.
- R5: With fixed_time=1, every operation takes 1+ERASE_CYC+PROG_CYC cycles, even when the word is blank.
- R6: With word_mode=1, stores to offsets 0,1,2,3 of one word, in that order, launch a cycle only on the fourth store. All four bytes are then written.
- R7: In word_mode=1, a partial load is discarded without touching the array or raising stall in two cases: a store to another word at a nonzero offset, or a store out of sequence. A store at offset 0 always begins a fresh load.
- R8: done is set in the cycle stall falls after an operation. It stays set until status_rd is pulsed or a new operation starts.
- R9: irq equals done while irq_en=1, and stays 0 while irq_en=0.
- R10: A store with wr_allow=0 leaves the array unchanged, does not raise stall, and sets wp_err. wp_err clears on status_rd or when the next operation starts.
- R11: Writing 0x00 to a byte leaves that byte reading 0x00. A word whose bytes have all been written to zero counts as blank for the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1: four-byte load mode, 0: single-byte mode |
| fixed_time | input | 1 | Force the erase phase on every operation |
| wr_allow | input | 1 | Target area writable (unlocked) |
| wr_en | input | 1 | Processor store strobe |
| wr_addr | input | ADDR_W (6) | Store byte address |
| wr_data | input | 8 | Store data |
| rd_addr | input | ADDR_W (6) | Read byte address |
| rd_data | output | 8 | Read data, one cycle after rd_addr |
| status_rd | input | 1 | Status read pulse, clears done and wp_err |
| irq_en | input | 1 | Interrupt enable for done |
| stall | output | 1 | Operation in progress; processor accesses held off |
| done | output | 1 | End-of-operation flag |
| wp_err | output | 1 | Protection-violation flag |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the processor honours stall: no store is presented while stall is high, and no read result taken during a cycle is relied on. The directed bench keeps to this. After every store that launches an operation, it waits on stall until it falls, and only then issues the next store or read. Stores for rejected or aborted loads are made only while stall is low.

// File: rtl/flashwp_pkg.sv
package flashwp_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_ERASE,
    SQ_WRITE
  } sq_state_t;

  localparam int LANES = 4;
endpackage

// File: rtl/flashwp_array.sv
module flashwp_array #(
  parameter int WORDS = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] raddr,
  output logic [31:0]      rdata,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [31:0]      wdata
);
  logic [31:0] cells [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/flashwp_loader.sv
module flashwp_loader #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             word_mode,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       off,
  input  logic [7:0]       data,
  output logic             start,
  output logic [IDX_W-1:0] start_idx,
  output logic [3:0]       start_mask,
  output logic [31:0]      start_data
);
  logic [2:0]       fill;
  logic [IDX_W-1:0] load_idx;
  logic [23:0]      held;
  logic             in_seq;

  assign in_seq = (fill != 3'd0) && (idx == load_idx) && (off == fill[1:0]);

  always_comb begin
    start      = 1'b0;
    start_idx  = idx;
    start_mask = 4'b0000;
    start_data = {4{data}};
    if (fire) begin
      if (!word_mode) begin
        start      = 1'b1;
        start_mask = 4'b0001 << off;
      end else if (in_seq && fill == 3'd3) begin
        start      = 1'b1;
        start_mask = 4'b1111;
        start_data = {data, held};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill     <= '0;
      load_idx <= '0;
      held     <= '0;
    end else if (fire && word_mode) begin
      if (in_seq) begin
        case (off)
          2'd1: held[15:8]  <= data;
          2'd2: held[23:16] <= data;
          default: ;
        endcase
        fill <= (fill == 3'd3) ? 3'd0 : fill + 3'd1;
      end else if (off == 2'd0) begin
        held[7:0] <= data;
        load_idx  <= idx;
        fill      <= 3'd1;
      end else begin
        fill <= 3'd0;
      end
    end else if (!word_mode) begin
      fill <= 3'd0;
    end
  end

  a_r6_fill_range: assert property (@(posedge clk) disable iff (rst) fill <= 3'd3);
  a_r7_stray_store_drops_load: assert property (@(posedge clk) disable iff (rst)
    (fire && word_mode && off != 2'd0 && fill != 3'd0 && idx != load_idx) |=> fill == 3'd0);
endmodule

// File: rtl/flashwp_seq.sv
module flashwp_seq
  import flashwp_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int ERASE_CYC = 6,
  parameter int PROG_CYC  = 4,
  localparam int CNT_MAX  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [3:0]       start_mask,
  input  logic [31:0]      start_data,
  input  logic [31:0]      old_word,
  input  logic             fixed_time,
  input  logic             reject,
  input  logic             status_rd,
  input  logic             irq_en,
  output logic             stall,
  output logic             done,
  output logic             wp_err,
  output logic             irq,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_waddr,
  output logic [31:0]      mem_wdata
);
  localparam logic [CNT_W-1:0] E_LAST = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PROG_CYC - 1);

  sq_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx_q;
  logic [3:0]       mask_q;
  logic [31:0]      data_q;
  logic [31:0]      merged_q;
  logic [31:0]      merged;
  logic             done_nxt;

  always_comb begin
    for (int b = 0; b < LANES; b++)
      merged[8*b +: 8] = mask_q[b] ? data_q[8*b +: 8] : old_word[8*b +: 8];
  end

  assign stall     = (state != SQ_IDLE);
  assign mem_we    = (state == SQ_WRITE) && (cnt == '0);
  assign mem_waddr = idx_q;
  assign mem_wdata = merged_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
      data_q   <= '0;
      merged_q <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          idx_q  <= start_idx;
          mask_q <= start_mask;
          data_q <= start_data;
          state  <= SQ_FETCH;
        end
        SQ_FETCH: begin
          merged_q <= merged;
          if (old_word != '0 || fixed_time) begin
            state <= SQ_ERASE;
            cnt   <= E_LAST;
          end else begin
            state <= SQ_WRITE;
            cnt   <= P_LAST;
          end
        end
        SQ_ERASE: if (cnt == '0) begin
          state <= SQ_WRITE;
          cnt   <= P_LAST;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: if (cnt == '0) state <= SQ_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  always_comb begin
    done_nxt = done;
    if (mem_we) done_nxt = 1'b1;
    else if (start || status_rd) done_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      wp_err <= 1'b0;
      irq    <= 1'b0;
    end else begin
      done <= done_nxt;
      irq  <= done_nxt && irq_en;
      if (reject) wp_err <= 1'b1;
      else if (start || status_rd) wp_err <= 1'b0;
    end
  end

  a_r3_stall_follows_start: assert property (@(posedge clk) disable iff (rst) start |=> stall);
  a_r3_blank_skips_erase: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_FETCH && old_word == '0 && !fixed_time) |=> state == SQ_WRITE);
  a_r5_fixed_forces_erase: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_FETCH && fixed_time) |=> state == SQ_ERASE);
  a_r8_done_from_write: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(mem_we));
  a_r8_write_ends_stall: assert property (@(posedge clk) disable iff (rst) mem_we |=> !stall);
  a_r8_status_clears: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !mem_we) |=> !done);
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(CNT_MAX));
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst) irq |-> $past(irq_en));
  a_r10_reject_no_stall: assert property (@(posedge clk) disable iff (rst) reject |=> !stall);
endmodule

// File: rtl/flashwp_ctrl.sv
module flashwp_ctrl #(
  parameter int WORDS     = 16,
  parameter int ERASE_CYC = 6,
  parameter int PROG_CYC  = 4,
  localparam int IDX_W    = $clog2(WORDS),
  localparam int ADDR_W   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode,
  input  logic              fixed_time,
  input  logic              wr_allow,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              status_rd,
  input  logic              irq_en,
  output logic              stall,
  output logic              done,
  output logic              wp_err,
  output logic              irq
);
  logic             fire, reject, start;
  logic [IDX_W-1:0] start_idx, raddr, mem_waddr;
  logic [3:0]       start_mask;
  logic [31:0]      start_data, word_q, mem_wdata;
  logic             mem_we;
  logic [1:0]       rd_off_q;

  assign fire   = wr_en && !stall && wr_allow;
  assign reject = wr_en && !stall && !wr_allow;
  assign raddr  = start ? start_idx : rd_addr[ADDR_W-1:2];

  flashwp_loader #(.IDX_W(IDX_W)) u_loader (
    .clk(clk), .rst(rst), .fire(fire), .word_mode(word_mode),
    .idx(wr_addr[ADDR_W-1:2]), .off(wr_addr[1:0]), .data(wr_data),
    .start(start), .start_idx(start_idx), .start_mask(start_mask),
    .start_data(start_data)
  );

  flashwp_array #(.WORDS(WORDS)) u_array (
    .clk(clk), .raddr(raddr), .rdata(word_q),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata)
  );

  flashwp_seq #(.IDX_W(IDX_W), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_idx(start_idx),
    .start_mask(start_mask), .start_data(start_data), .old_word(word_q),
    .fixed_time(fixed_time), .reject(reject), .status_rd(status_rd),
    .irq_en(irq_en), .stall(stall), .done(done), .wp_err(wp_err), .irq(irq),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_off_q <= '0;
    else     rd_off_q <= rd_addr[1:0];
  end

  assign rd_data = word_q[{rd_off_q, 3'b000} +: 8];

  a_r3_no_store_while_stalled: assert property (@(posedge clk) disable iff (rst)
    stall |-> !wr_en);
  a_r10_reject_keeps_array: assert property (@(posedge clk) disable iff (rst)
    reject |-> !start);
endmodule

// File: tb/flashwp_ctrl_test.sv
module flashwp_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       word_mode = 1'b0, fixed_time = 1'b0, wr_allow = 1'b1;
  logic       wr_en = 1'b0, status_rd = 1'b0, irq_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       stall, done, wp_err, irq;
  int         n_chk = 0, n_fail = 0, cycles = 0;

  always #5 clk = ~clk;

  flashwp_ctrl uut (
    .clk(clk), .rst(rst), .word_mode(word_mode), .fixed_time(fixed_time),
    .wr_allow(wr_allow), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .status_rd(status_rd),
    .irq_en(irq_en), .stall(stall), .done(done), .wp_err(wp_err), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic store(input logic [5:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stall_len(output int n);
    n = 0;
    while (stall && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic peek(input logic [5:0] a, output logic [7:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic pulse_status();
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 stall", stall, 0); chk("R1 done", done, 0);
    chk("R1 wp_err", wp_err, 0); chk("R1 irq", irq, 0);
    for (int a = 0; a < 64; a += 7) begin peek(6'(a), v); chk("R1 array", v, 0); end
  endtask

  task automatic t_byte();
    int n; logic [7:0] v;
    store(6'h09, 8'hA5); stall_len(n);
    chk("R3 blank byte cycles", n, 5);
    chk("R8 done set", done, 1);
    peek(6'h09, v); chk("R2 byte written", v, 8'hA5);
    peek(6'h08, v); chk("R2 neighbour0", v, 0);
    peek(6'h0A, v); chk("R2 neighbour2", v, 0);
    store(6'h0A, 8'h3C); stall_len(n);
    chk("R4 nonblank byte cycles", n, 11);
    peek(6'h09, v); chk("R2 merge keeps old", v, 8'hA5);
    peek(6'h0A, v); chk("R2 merged byte", v, 8'h3C);
    chk("R8 done holds", done, 1);
    pulse_status(); chk("R8 status clears done", done, 0);
  endtask

  task automatic t_irq();
    int n;
    irq_en = 1'b1;
    store(6'h0C, 8'h01); stall_len(n);
    chk("R9 irq with done", irq, 1);
    pulse_status(); chk("R9 irq clears", irq, 0);
    irq_en = 1'b0;
    store(6'h0D, 8'h02); stall_len(n);
    chk("R9 done without irq", done, 1); chk("R9 irq masked", irq, 0);
    store(6'h0E, 8'h03);
    chk("R8 new op clears done", done, 0);
    stall_len(n);
  endtask

  task automatic t_fixed();
    int n;
    fixed_time = 1'b1;
    store(6'h10, 8'h11); stall_len(n);
    chk("R5 forced erase on blank", n, 11);
    fixed_time = 1'b0;
  endtask

  task automatic t_word();
    int n; logic [7:0] v;
    word_mode = 1'b1;
    store(6'h14, 8'h01); chk("R6 no start after byte0", stall, 0);
    store(6'h15, 8'h02); chk("R6 no start after byte1", stall, 0);
    store(6'h16, 8'h03); chk("R6 no start after byte2", stall, 0);
    store(6'h17, 8'h04); stall_len(n);
    chk("R6 word blank cycles", n, 5);
    for (int k = 0; k < 4; k++) begin peek(6'(8'h14 + k), v); chk("R6 word byte", v, k + 1); end
    store(6'h14, 8'hF0); store(6'h15, 8'hF1); store(6'h16, 8'hF2); store(6'h17, 8'hF3);
    stall_len(n);
    chk("R4 word nonblank cycles", n, 11);
    peek(6'h17, v); chk("R6 word overwrite", v, 8'hF3);
    word_mode = 1'b0;
  endtask

  task automatic t_abort();
    logic [7:0] v;
    word_mode = 1'b1;
    store(6'h18, 8'hAA); store(6'h19, 8'hBB);
    store(6'h1E, 8'hCC);
    store(6'h1A, 8'hDD); store(6'h1B, 8'hEE);
    chk("R7 other word aborts", stall, 0);
    store(6'h18, 8'h10); store(6'h1A, 8'h11);
    store(6'h1B, 8'h12);
    chk("R7 out of order aborts", stall, 0);
    peek(6'h18, v); chk("R7 word6 untouched", v, 0);
    peek(6'h1B, v); chk("R7 word6 untouched hi", v, 0);
    store(6'h18, 8'h21); store(6'h19, 8'h22); store(6'h1A, 8'h23); store(6'h1B, 8'h24);
    chk("R7 fresh load starts", stall, 1);
    begin int n; stall_len(n); end
    peek(6'h18, v); chk("R7 fresh load byte0", v, 8'h21);
    word_mode = 1'b0;
  endtask

  task automatic t_protect();
    int n; logic [7:0] v;
    wr_allow = 1'b0;
    store(6'h30, 8'h77);
    chk("R10 no stall on reject", stall, 0);
    chk("R10 wp_err set", wp_err, 1);
    peek(6'h30, v); chk("R10 array unchanged", v, 0);
    pulse_status(); chk("R10 status clears wp_err", wp_err, 0);
    store(6'h30, 8'h77);
    wr_allow = 1'b1;
    store(6'h31, 8'h05);
    chk("R10 new op clears wp_err", wp_err, 0);
    stall_len(n);
  endtask

  task automatic t_zero();
    int n; logic [7:0] v;
    store(6'h09, 8'h00); stall_len(n);
    peek(6'h09, v); chk("R11 zero write", v, 0);
    store(6'h0A, 8'h00); stall_len(n);
    chk("R4 nonblank before last zero", n, 11);
    store(6'h08, 8'h55); stall_len(n);
    chk("R11 zeroed word is blank", n, 5);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte();
    t_irq();
    t_fixed();
    t_word();
    t_abort();
    t_protect();
    t_zero();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule